// File: doc/BRIEF.md
# Configurable Synchronous Serial Channel

This block is a clock-synchronous serial channel that acts as clock master. One 8-bit control byte sets its behaviour. The byte picks the prescaler that feeds the baud divider, the flow-control role of one shared handshake pin, the serial clock polarity and the bit order. A second byte-wide register holds the baud divisor.

The host loads one byte into the transmit shift register. When the handshake allows it, the channel drives eight serial clock periods. It shifts the byte out on `sdo` and gathers eight bits from `sdi` at the same time. At the end of the frame the received byte is kept until the host acknowledges it. A read-only flag in the control byte tells the host whether the transmit register is still occupied.

Top module: `ssx_channel`

## Requirements
- R1: After reset the control byte reads 0x08 and the divisor reads 0x00. `sclk` and `sdo` are high, `hs_oe` is 0 and `rx_valid` is 0.
- R2: Control bits [1:0] select the prescale ratio: 00 gives 1, 01 gives 8 and 10 gives 32. Each serial clock half-period lasts (divisor+1) × ratio clock cycles, and one frame has 16 `sclk` edges.
- R3: A write with bits [1:0] = 11 keeps the previous ratio selection. Writes to bit 3 and bit 5 have no effect, and bit 5 reads 0.
- R4: Control bit 3 reads 0 from the cycle a byte is loaded until its frame ends, and 1 otherwise. A transmit write while bit 3 is 0 is ignored.
- R5: With control bit 6 = 0, `sclk` idles high, `sdo` changes on falling edges and `sdi` is sampled on rising edges. With bit 6 = 1, `sclk` idles low and both edges swap roles.
- R6: Control bit 7 = 0 sends the LSB first; bit 7 = 1 sends the MSB first.
- R7: The bits sampled from `sdi` are assembled using the same bit order as transmit. `rx_data` and `rx_valid` are set when the frame ends, and `rx_ack` clears `rx_valid`.
- R8: With bit 4 = 0 and bit 2 = 0 (CTS role), a loaded frame starts only while `hs_in` is low, and `hs_oe` is 0.
- R9: With bit 4 = 0 and bit 2 = 1 (RTS role), `hs_oe` is 1. `hs_out` is low while no received byte is pending and high while `rx_valid` is set.
- R10: With bit 4 = 1, `hs_in` has no effect on frame start and `hs_oe` is 0, whatever bit 2 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control byte, 1 selects the divisor |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ack | input | 1 | Clears the pending flag |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| hs_in | input | 1 | Handshake pin input (CTS role) |
| hs_out | output | 1 | Handshake pin output value (RTS role) |
| hs_oe | output | 1 | Handshake pin output enable |

## Verification
A table of frames covers all three prescale ratios, several divisor values, both polarities and both bit orders. Each frame uses asymmetric transmit and receive bytes, so a reversed bit order, a swapped edge or a wrong half-period shows up as a distinct mismatch in the captured byte, the received byte or the edge spacing. Directed cases hold `hs_in` high in CTS role to show that a frame is blocked, then release it. In RTS role they check that the pin follows the pending received byte. They also try the reserved ratio code, writes to read-only bits, and a second transmit write while busy.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned MAX_RATIO = 32;
  localparam int unsigned PCNT_W    = $clog2(MAX_RATIO);

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_RSVD  = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic     msb_first;
    logic     pol;
    logic     flow_off;
    logic     rts_mode;
    src_sel_e src;
  } ctrl_t;

  function automatic int unsigned src_ratio(src_sel_e s);
    case (s)
      SRC_DIV8:  return 8;
      SRC_DIV32: return 32;
      default:   return 1;
    endcase
  endfunction

  function automatic ctrl_t ctrl_merge(ctrl_t cur, logic [REG_W-1:0] wd);
    ctrl_t n;
    n.msb_first = wd[7];
    n.pol       = wd[6];
    n.flow_off  = wd[4];
    n.rts_mode  = wd[2];
    n.src       = (wd[1:0] == 2'b11) ? cur.src : src_sel_e'(wd[1:0]);
    return n;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_view(ctrl_t c, logic empty);
    return {c.msb_first, c.pol, 1'b0, c.flow_off, empty, c.rts_mode, c.src};
  endfunction
endpackage

// File: rtl/ssx_ctrl_reg.sv
module ssx_ctrl_reg
  import ssx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             tx_empty,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] divisor,
  output logic [REG_W-1:0] rdata,
  output logic             baud_reload
);
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (we) begin
      if (sel) div_q  <= wdata;
      else     ctrl_q <= ctrl_merge(ctrl_q, wdata);
    end
  end

  assign ctrl        = ctrl_q;
  assign divisor     = div_q;
  assign baud_reload = we;
  assign rdata       = sel ? div_q : ctrl_view(ctrl_q, tx_empty);
endmodule

// File: rtl/ssx_baud.sv
module ssx_baud
  import ssx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  src_sel_e         src,
  input  logic [REG_W-1:0] divisor,
  output logic             half_tick
);
  logic [PCNT_W-1:0] pcnt;
  logic [REG_W-1:0]  dcnt;
  logic [PCNT_W-1:0] plimit;
  logic              pre_tick;

  assign plimit    = PCNT_W'(src_ratio(src) - 1);
  assign pre_tick  = run && (pcnt == plimit);
  assign half_tick = pre_tick && (dcnt == divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (!run || reload) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (pre_tick) begin
      pcnt <= '0;
      dcnt <= (dcnt == divisor) ? '0 : dcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tx_we,
  input  logic [DATA_W-1:0]         tx_data,
  input  logic                      cts_ok,
  input  logic                      half_tick,
  input  logic                      msb_first,
  input  logic                      rx_ack,
  input  logic                      sdi,
  output logic                      running,
  output logic                      loaded,
  output logic                      phase,
  output logic                      sdo_bit,
  output logic [$clog2(DATA_W)-1:0] bit_cnt,
  output logic [DATA_W-1:0]         rx_data,
  output logic                      rx_valid,
  output logic                      frame_start,
  output logic                      frame_done
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              last_bit;

  assign last_bit    = (bit_cnt == CNT_W'(DATA_W - 1));
  assign frame_start = loaded && !running && cts_ok;
  assign frame_done  = running && half_tick && phase && last_bit;
  assign sdo_bit     = msb_first ? tx_sh[DATA_W-1] : tx_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      loaded  <= 1'b0;
      running <= 1'b0;
      phase   <= 1'b0;
      bit_cnt <= '0;
      rx_data <= '0;
    end else begin
      if (tx_we && !loaded) begin
        tx_sh  <= tx_data;
        loaded <= 1'b1;
      end
      if (frame_start) begin
        running <= 1'b1;
        phase   <= 1'b0;
        bit_cnt <= '0;
      end else if (running && half_tick) begin
        if (!phase) begin
          phase <= 1'b1;
          rx_sh <= msb_first ? {rx_sh[DATA_W-2:0], sdi} : {sdi, rx_sh[DATA_W-1:1]};
        end else if (last_bit) begin
          running <= 1'b0;
          loaded  <= 1'b0;
          rx_data <= rx_sh;
        end else begin
          phase   <= 1'b0;
          bit_cnt <= bit_cnt + 1'b1;
          tx_sh   <= msb_first ? (tx_sh << 1) : (tx_sh >> 1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_valid <= 1'b0;
    else if (frame_done) rx_valid <= 1'b1;
    else if (rx_ack)     rx_valid <= 1'b0;
  end
endmodule

// File: rtl/ssx_channel.sv
module ssx_channel
  import ssx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tx_we,
  input  logic [REG_W-1:0] tx_data,
  output logic [REG_W-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ack,
  output logic             sclk,
  output logic             sdo,
  input  logic             sdi,
  input  logic             hs_in,
  output logic             hs_out,
  output logic             hs_oe
);
  localparam int unsigned CNT_W = $clog2(REG_W);

  ctrl_t            ctrl;
  logic [REG_W-1:0] divisor;
  logic             baud_reload;
  logic             half_tick;
  logic             running;
  logic             loaded;
  logic             phase;
  logic             sdo_bit;
  logic [CNT_W-1:0] bit_cnt;
  logic             frame_start;
  logic             frame_done;
  logic             tx_empty;
  logic             cts_ok;

  assign tx_empty = !loaded;
  assign cts_ok   = ctrl.flow_off || ctrl.rts_mode || !hs_in;

  ssx_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .tx_empty(tx_empty), .ctrl(ctrl), .divisor(divisor), .rdata(reg_rdata),
    .baud_reload(baud_reload)
  );

  ssx_baud u_baud (
    .clk(clk), .rst_n(rst_n), .run(running), .reload(baud_reload),
    .src(ctrl.src), .divisor(divisor), .half_tick(half_tick)
  );

  ssx_shifter #(.DATA_W(REG_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .tx_data(tx_data), .cts_ok(cts_ok),
    .half_tick(half_tick), .msb_first(ctrl.msb_first), .rx_ack(rx_ack), .sdi(sdi),
    .running(running), .loaded(loaded), .phase(phase), .sdo_bit(sdo_bit),
    .bit_cnt(bit_cnt), .rx_data(rx_data), .rx_valid(rx_valid),
    .frame_start(frame_start), .frame_done(frame_done)
  );

  assign sclk   = running ? (phase ? !ctrl.pol : ctrl.pol) : !ctrl.pol;
  assign sdo    = running ? sdo_bit : 1'b1;
  assign hs_oe  = !ctrl.flow_off && ctrl.rts_mode;
  assign hs_out = hs_oe ? rx_valid : 1'b1;
endmodule

// File: rtl/ssx_channel_chk.sv
module ssx_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] src,
  input logic       running,
  input logic       half_tick,
  input logic       frame_start,
  input logic       frame_done,
  input logic       tx_empty,
  input logic       sclk,
  input logic       hs_in,
  input logic       flow_off,
  input logic       rts_mode,
  input logic       hs_out,
  input logic       hs_oe,
  input logic       rx_valid
);
  p_src_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src != 2'b11);

  p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !flow_off && !rts_mode) |-> !hs_in);

  p_busy_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !tx_empty);

  p_sclk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(half_tick)) |-> $stable(sclk));

  p_rx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_valid);

  p_rts_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rts_mode && !flow_off) |=> hs_out);

  p_pin_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flow_off |-> !hs_oe);
endmodule

bind ssx_channel ssx_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src(ctrl.src), .running(running),
  .half_tick(half_tick), .frame_start(frame_start), .frame_done(frame_done),
  .tx_empty(tx_empty), .sclk(sclk), .hs_in(hs_in), .flow_off(ctrl.flow_off),
  .rts_mode(ctrl.rts_mode), .hs_out(hs_out), .hs_oe(hs_oe), .rx_valid(rx_valid)
);

// File: tb/tb_ssx_channel.sv
module tb_ssx_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_we = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ack = 1'b0;
  logic       sclk;
  logic       sdo;
  logic       sdi = 1'b0;
  logic       hs_in = 1'b0;
  logic       hs_out;
  logic       hs_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ssx_channel dut (.*);

  // cycle counter and serial line monitor
  int   cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       mon_pol = 1'b0;
  logic       mon_msb = 1'b0;
  logic [7:0] rx_pat = '0;
  logic [7:0] cap = '0;
  logic       sclk_prev = 1'b1;
  int edges = 0, sh_idx = 0, sm_idx = 0, last_cyc = 0, gmin = 0, gmax = 0;

  always @(negedge clk) begin
    if (sclk !== sclk_prev) begin
      if (edges > 0) begin
        if (cyc - last_cyc > gmax) gmax = cyc - last_cyc;
        if (cyc - last_cyc < gmin) gmin = cyc - last_cyc;
      end
      last_cyc = cyc;
      edges++;
      if (sclk == mon_pol) begin
        if (sh_idx < 8) sdi = mon_msb ? rx_pat[7-sh_idx] : rx_pat[sh_idx];
        sh_idx++;
      end else begin
        if (sm_idx < 8) begin
          if (mon_msb) cap[7-sm_idx] = sdo;
          else         cap[sm_idx]   = sdo;
        end
        sm_idx++;
      end
    end
    sclk_prev = sclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic reg_rd(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic tx_wr(input logic [7:0] d);
    @(negedge clk); tx_we = 1'b1; tx_data = d;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic ack_rx();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic mon_arm(input logic [7:0] ctrl, input logic [7:0] rxp);
    @(posedge clk);
    mon_pol = ctrl[6]; mon_msb = ctrl[7]; rx_pat = rxp;
    edges = 0; sh_idx = 0; sm_idx = 0; gmin = 1 << 20; gmax = 0; cap = '0;
    sclk_prev = sclk;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (reg_rdata[3]) break;
    end
  endtask

  function automatic int exp_half(input logic [7:0] ctrl, input logic [7:0] dv);
    int r;
    r = (ctrl[1:0] == 2'b01) ? 8 : (ctrl[1:0] == 2'b10) ? 32 : 1;
    return (int'(dv) + 1) * r;
  endfunction

  // {ctrl, divisor, tx byte, rx byte}
  localparam logic [31:0] VEC [6] = '{
    32'h10_00_A5_3C,   // pol0 lsb ratio1
    32'hD1_01_81_7E,   // pol1 msb ratio8
    32'h92_00_0F_F0,   // pol0 msb ratio32
    32'h50_03_6B_D2,   // pol1 lsb ratio1 div3
    32'h14_02_C3_1E,   // rts bit with flow off
    32'h81_00_55_AA    // CTS role, msb ratio8
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_rd(1'b0, rd); chk(rd == 8'h08, "R1 ctrl reset", rd, 8'h08);
    reg_rd(1'b1, rd); chk(rd == 8'h00, "R1 divisor reset", rd, 8'h00);
    chk(sclk == 1'b1 && sdo == 1'b1, "R1 idle lines", {sclk, sdo}, 2'b11);
    chk(hs_oe == 1'b0 && rx_valid == 1'b0, "R1 hs_oe/rx_valid", {hs_oe, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) begin
      logic [7:0] c, dv, tb, rb;
      {c, dv, tb, rb} = VEC[k];
      hs_in = c[4];
      reg_wr(1'b1, dv);
      reg_wr(1'b0, c);
      reg_rd(1'b0, rd); chk(rd == (c | 8'h08), "R2 ctrl readback", rd, c | 8'h08);
      reg_rd(1'b1, rd); chk(rd == dv, "R2 divisor readback", rd, dv);
      chk(sclk == !c[6], "R5 idle level", sclk, !c[6]);
      if (c[4]) chk(hs_oe == 1'b0, "R10 pin released", hs_oe, 0);
      mon_arm(c, rb);
      tx_wr(tb);
      wait_done();
      chk(cap == tb, "R6 R5 transmitted byte", cap, tb);
      chk(edges == 16, "R2 edge count", edges, 16);
      chk(gmin == exp_half(c, dv) && gmax == exp_half(c, dv), "R2 half period", gmax, exp_half(c, dv));
      chk(rx_valid && rx_data == rb, "R7 received byte", {rx_valid, rx_data}, {1'b1, rb});
      ack_rx();
      chk(rx_valid == 1'b0, "R7 ack clears", rx_valid, 0);
    end

    // R3 reserved ratio code and read-only bits
    reg_wr(1'b0, 8'h01);
    reg_wr(1'b0, 8'h03);
    reg_rd(1'b0, rd); chk(rd == 8'h09, "R3 reserved code kept", rd, 8'h09);
    reg_wr(1'b0, 8'h2B);
    reg_rd(1'b0, rd); chk(rd == 8'h09, "R3 read-only bits", rd, 8'h09);
    reg_wr(1'b0, 8'h02);
    reg_rd(1'b0, rd); chk(rd == 8'h0A, "R3 legal code taken", rd, 8'h0A);

    // R8 CTS blocking, R4 busy flag and ignored second write
    reg_wr(1'b1, 8'h00);
    reg_wr(1'b0, 8'h00);
    hs_in = 1'b1;
    mon_arm(8'h00, 8'h99);
    tx_wr(8'h12);
    reg_rd(1'b0, rd); chk(rd[3] == 1'b0, "R4 flag clear when loaded", rd[3], 0);
    tx_wr(8'h34);
    repeat (40) @(negedge clk);
    chk(edges == 0 && sclk == 1'b1, "R8 frame blocked by hs_in high", edges, 0);
    reg_rd(1'b0, rd); chk(rd[3] == 1'b0, "R4 flag held while blocked", rd[3], 0);
    chk(hs_oe == 1'b0, "R8 pin is input", hs_oe, 0);
    hs_in = 1'b0;
    wait_done();
    chk(cap == 8'h12, "R4 second write ignored", cap, 8'h12);
    chk(rx_data == 8'h99, "R8 frame after release", rx_data, 8'h99);
    ack_rx();

    // R9 RTS role
    reg_wr(1'b0, 8'h04);
    hs_in = 1'b1;
    chk(hs_oe == 1'b1 && hs_out == 1'b0, "R9 ready low", {hs_oe, hs_out}, 2'b10);
    mon_arm(8'h04, 8'h5A);
    tx_wr(8'hE7);
    wait_done();
    chk(hs_out == 1'b1, "R9 pending high", hs_out, 1);
    chk(cap == 8'hE7, "R9 frame ignores hs_in", cap, 8'hE7);
    ack_rx();
    chk(hs_out == 1'b0, "R9 low after ack", hs_out, 0);

    // R10 flow off with CTS-role bit: hs_in high does not block
    reg_wr(1'b0, 8'h10);
    mon_arm(8'h10, 8'h0C);
    tx_wr(8'h3A);
    wait_done();
    chk(cap == 8'h3A && rx_data == 8'h0C, "R10 hs_in ignored", {cap, rx_data}, 16'h3A0C);
    ack_rx();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule